// File: doc/BRIEF.md
# Gear Interval Timer

This block is a free-running timing unit for equalizer adaptation control. After a synchronous reset is released, it counts cycles of the reconfiguration clock. It issues four one-shot gear strobes, one after another. Each strobe tells downstream logic to step the adaptation loop bandwidth down by one notch. The last strobe selects the lowest bandwidth, which then stays in force.

The strobe times are multiples of a base interval. The base interval is worked out offline as the clock frequency in MHz times 12.5, divided by the line rate in Gb/s, and it reaches the block on an input. The spacing of the strobes depends on the equalizer mode:

- In decision-feedback mode the strobes fall at 1, 4, 16 and 64 base intervals, so each one is four times later than the one before.
- In low-power linear mode the strobes fall at 1, 2, 3 and 4 base intervals, so they are evenly spaced.

The mode and the base interval are captured while reset is held. After the fourth strobe the counter stops, and a done flag stays high until the next reset.

Top module: `gear_interval_timer`

## Requirements
- R1: The cycle counter is 32 bits wide and starts at zero. Counting the rising edges at which reset is sampled low, a gear output is high in the cycle that follows edge number T, where T is that gear's threshold.
- R2: With `mode_lpm` = 0 (decision-feedback), the thresholds for gear_pulse[0..3] are 1, 4, 16 and 64 times the base interval.
- R3: With `mode_lpm` = 1 (low-power linear), the thresholds for gear_pulse[0..3] are 1, 2, 3 and 4 times the base interval.
- R4: `mode_lpm` and `base_interval` are captured on every clock edge while `rst` is high. Changes to them after reset is released have no effect on the strobe times.
- R5: A base interval of zero is treated as one.
- R6: Each gear output is a single-cycle pulse. It fires once per reset release, in gear order, and no two gears are ever high in the same cycle.
- R7: `done` rises in the same cycle as gear_pulse[3] and stays high until reset. No gear pulse occurs while `done` is high.
- R8: While `rst` is high, every output is low in the cycle after each edge. A reset in the middle of a run restarts the schedule from zero with the newly captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reconfiguration clock |
| rst | input | 1 | Synchronous active-high reset; settings are captured while it is high |
| mode_lpm | input | 1 | 0 = decision-feedback spacing, 1 = low-power linear spacing |
| base_interval | input | 26 | Base interval in clock cycles (zero is treated as one) |
| gear_pulse | output | 4 | One-cycle gear strobes; bit 0 is gear 1 |
| done | output | 1 | Sticky flag, high from the gear 4 strobe until reset |

## Verification
The bench predicts the exact strobe cycle of every gear in both modes. A design that spaced the strobes evenly in decision-feedback mode, or that was one cycle off in its counter, would produce a pulse on the wrong cycle. A base interval of one in low-power mode puts all four strobes on consecutive cycles. A design that stretched its pulses or merged adjacent gears would show extra or overlapping pulses there.

The bench also changes the mode and the base interval just after reset is released, and resets the block halfway through a run. A design that read its settings live, or that kept stale state across a reset, would fire at the wrong times. The zero base interval checks the clamp to one: without it the design would hang or fire at once.

// File: rtl/gear_timer_pkg.sv
package gear_timer_pkg;
  localparam int unsigned NUM_GEARS = 4;

  // Multiplier for gear index g (0-based) in each equalizer mode.
  function automatic int unsigned gear_mult(input logic lpm, input int unsigned g);
    if (lpm) gear_mult = g + 1;           // 1,2,3,4
    else     gear_mult = 1 << (2 * g);    // 1,4,16,64
  endfunction
endpackage

// File: rtl/gear_threshold_gen.sv
module gear_threshold_gen
  import gear_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BASE_W = CNT_W - 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mode_lpm,
  input  logic [BASE_W-1:0]             base_interval,
  output logic [NUM_GEARS-1:0][CNT_W-1:0] thr
);
  logic [CNT_W-1:0] base_eff;

  // Zero interval is clamped to one cycle.
  always_comb begin
    base_eff = CNT_W'(base_interval);
    if (base_interval == '0) base_eff = CNT_W'(1);
  end

  for (genvar g = 0; g < NUM_GEARS; g++) begin : g_thr
    localparam int unsigned DFE_M = gear_mult(1'b0, g);
    localparam int unsigned LPM_M = gear_mult(1'b1, g);
    logic [CNT_W-1:0] prod;

    always_comb begin
      if (mode_lpm) prod = base_eff * CNT_W'(LPM_M);
      else          prod = base_eff * CNT_W'(DFE_M);
    end

    // Settings are latched only while reset is held.
    always_ff @(posedge clk) begin
      if (rst) thr[g] <= prod;
    end
  end
endmodule

// File: rtl/gear_strobe.sv
module gear_strobe #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halted,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [CNT_W-1:0] thr,
  output logic             pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= !halted && (cnt_next == thr);
  end
endmodule

// File: rtl/gear_interval_timer.sv
module gear_interval_timer
  import gear_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BASE_W = CNT_W - 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_lpm,
  input  logic [BASE_W-1:0]    base_interval,
  output logic [NUM_GEARS-1:0] gear_pulse,
  output logic                 done
);
  localparam int LAST = NUM_GEARS - 1;

  logic [NUM_GEARS-1:0][CNT_W-1:0] thr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;

  gear_threshold_gen #(.CNT_W(CNT_W), .BASE_W(BASE_W)) thr_i (
    .clk(clk), .rst(rst), .mode_lpm(mode_lpm),
    .base_interval(base_interval), .thr(thr)
  );

  assign cnt_next = cnt + CNT_W'(1);

  // Elapsed-cycle counter; freezes once the schedule completes.
  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (!done) cnt <= cnt_next;
  end

  for (genvar g = 0; g < NUM_GEARS; g++) begin : g_strobe
    gear_strobe #(.CNT_W(CNT_W)) strobe_i (
      .clk(clk), .rst(rst), .halted(done),
      .cnt_next(cnt_next), .thr(thr[g]), .pulse(gear_pulse[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                           done <= 1'b0;
    else if (cnt_next == thr[LAST])    done <= 1'b1;
  end
endmodule

// File: rtl/gear_interval_timer_chk.sv
module gear_interval_timer_chk #(
  parameter int NG = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [NG-1:0] gear_pulse,
  input logic          done
);
  AST_GEARS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gear_pulse)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R7
  AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> gear_pulse[NG-1]); // R7
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> (gear_pulse == '0)); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (gear_pulse == '0 && !done)); // R8
  for (genvar g = 0; g < NG; g++) begin : g_single
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      gear_pulse[g] |=> !gear_pulse[g]); // R6
  end
endmodule

bind gear_interval_timer gear_interval_timer_chk #(.NG(4)) chk_i (
  .clk(clk), .rst(rst), .gear_pulse(gear_pulse), .done(done)
);

// File: tb/gear_interval_timer_tb_top.sv
module gear_interval_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_lpm = 1'b0;
  logic [25:0] base_interval = '0;
  logic [3:0]  gear_pulse;
  logic        done;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int exp_done_cyc = 0;
  bit mon_en = 1'b0;
  int q_gear[$];
  int q_cyc[$];

  always #5 clk = ~clk;

  gear_interval_timer dut_i (
    .clk(clk), .rst(rst), .mode_lpm(mode_lpm),
    .base_interval(base_interval), .gear_pulse(gear_pulse), .done(done)
  );

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  // Monitor: compare observed strobes against the scoreboard queue.
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      for (int g = 0; g < 4; g++) begin
        if (gear_pulse[g]) begin
          tests++;
          if (q_gear.size() == 0) begin
            fails++;
            $display("FAIL R6: unexpected gear %0d at cycle %0d, expected none", g + 1, cyc);
          end else if (q_gear[0] != g || q_cyc[0] != cyc) begin
            fails++;
            $display("FAIL R1/R2/R3: gear %0d at cycle %0d, expected gear %0d at cycle %0d",
                     g + 1, cyc, q_gear[0] + 1, q_cyc[0]);
            void'(q_gear.pop_front()); void'(q_cyc.pop_front());
          end else begin
            void'(q_gear.pop_front()); void'(q_cyc.pop_front());
          end
        end
      end
      if (done != (cyc >= exp_done_cyc)) begin
        tests++; fails++;
        $display("FAIL R7: done=%0b at cycle %0d, expected %0b", done, cyc, cyc >= exp_done_cyc);
      end
    end
  end

  task automatic check_reset_state();
    tests++;
    if (gear_pulse !== 4'b0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R8: in reset pulse=%b done=%b, expected 0000/0", gear_pulse, done);
    end
  endtask

  // Driver: capture settings under reset, push expected strobes, run.
  task automatic run_case(input bit lpm, input int base, input bit late_change, input int stop_at);
    int b;
    int last;
    b = (base == 0) ? 1 : base;
    rst = 1'b1;
    mode_lpm = lpm;
    base_interval = 26'(base);
    repeat (3) @(negedge clk);
    check_reset_state(); // R8
    q_gear.delete(); q_cyc.delete();
    for (int g = 0; g < 4; g++) begin
      q_gear.push_back(g);
      q_cyc.push_back(lpm ? b * (g + 1) : b * (1 << (2 * g))); // R2 R3 R5
    end
    last = q_cyc[3];
    exp_done_cyc = last;
    mon_en = 1'b1;
    rst = 1'b0;
    if (late_change) begin // R4: ignored after release
      @(negedge clk);
      mode_lpm = ~lpm;
      base_interval = 26'(b * 3 + 2);
    end
    if (stop_at > 0) begin
      while (cyc < stop_at) @(negedge clk);
      mon_en = 1'b0;
      return;
    end
    while (cyc < last + 12) @(negedge clk);
    tests++;
    if (q_gear.size() != 0) begin
      fails++;
      $display("FAIL R6: %0d strobes missing, expected 0", q_gear.size());
    end
    tests++;
    if (done !== 1'b1 || gear_pulse !== 4'b0) begin
      fails++;
      $display("FAIL R7: end done=%b pulse=%b, expected 1/0000", done, gear_pulse);
    end
    mon_en = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run hung, expected completion");
      end
      begin
        run_case(1'b0, 5, 1'b0, 0);   // R2 decision-feedback spacing
        run_case(1'b1, 7, 1'b0, 0);   // R3 low-power spacing
        run_case(1'b1, 1, 1'b0, 0);   // R6 adjacent strobes
        run_case(1'b0, 0, 1'b0, 0);   // R5 zero clamps to one
        run_case(1'b1, 3, 1'b1, 0);   // R4 late change ignored
        run_case(1'b0, 4, 1'b0, 30);  // R8 interrupted run
        rst = 1'b1;
        @(negedge clk);
        check_reset_state();          // R8 cleared after mid-run reset
        run_case(1'b0, 9, 1'b1, 0);   // R8 restart, R1 counts from zero
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule